// File: doc/BRIEF.md
# Edge-Triggered External Event Bank

This block watches 32 external input lines and turns selected transitions on them into latched interrupt requests. Each line first passes through a two-flop synchronizer. Software can pick the rising edge, the falling edge, both edges or neither for each line. A detected rising transition sets a bit in one pending register, and a falling transition sets a bit in a second pending register. Software clears each register separately by writing ones to it.

A line mask enables each line onto a single registered interrupt output and onto a registered per-line output vector. A build-time capability vector marks each line as configurable or direct. Configurable lines use the edge and pending logic. Direct lines skip that logic: their synchronized level, gated only by the mask, goes straight to the per-line output. Software can also inject an event on any configurable line through a trigger register.

The register interface is a 32-bit valid/ready bus that is always ready. A read returns its data one cycle after it is accepted.

Top module: `ext_event_bank`

## Requirements
- R1: After reset, the following are all zero: the rising-select, falling-select and mask registers, both pending registers, `irq_out`, `line_out` and `rsp_valid`.
- R2: On a configurable line n with bit n set in the rising-select register (offset 0x00), a low-to-high transition of `lines_in[n]` sets bit n of the rising pending register (offset 0x0C). It does not change the falling pending register.
- R3: On a configurable line n with bit n set in the falling-select register (offset 0x04), a high-to-low transition sets bit n of the falling pending register (offset 0x10). It does not change the rising pending register.
- R4: A line with both select bits set latches on each transition, into the register that matches the transition's direction. A line with neither select bit set never latches a transition.
- R5: Writing to either pending register clears exactly the bits written as 1. Bits written as 0 keep their value, and the other pending register is not affected.
- R6: Writing to the trigger register (offset 0x08) sets the rising pending bit of every configurable line whose data bit is 1, in the cycle the write is accepted. This happens whatever the select bits hold. The trigger register reads as zero.
- R7: The mask register (offset 0x80) reads back what was last written. One cycle after the pending or mask state changes, `irq_out` equals the OR over all lines of (rising pending OR falling pending) AND mask.
- R8: The capability register (offset 0x84) is read-only and returns the `CAP_LINES` parameter, in which 1 means configurable. A direct line never sets a pending bit, even when it transitions or is triggered by software. Its `line_out` bit follows its synchronized level AND its mask bit. A configurable line's `line_out` bit is (its rising pending OR falling pending) AND its mask bit.
- R9: If a transition sets a pending bit in the same cycle that a clearing write targets that bit, the bit remains set.
- R10: A read at any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x80 and 0x84 returns zero. A write to such an offset changes no register.
- R11: `req_ready` is always high. `rsp_valid` is high exactly in the cycle after a read is accepted, and `rsp_rdata` holds the read value in that cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| lines_in | input | 32 | Asynchronous external event lines |
| line_out | output | 32 | Per-line masked request or masked direct level |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
The bench drives random sequences of line toggles, select writes, mask writes, one-hot clears and software triggers. It checks the outputs and registers against a model that tracks which transitions should latch. Random select patterns show whether rising and falling transitions are routed to the correct pending register. Toggling lines that have both or neither select bit set shows whether the dual-edge and disabled cases are decoded correctly.

Directed cases cover the remaining behaviour:
- a transition that lands in the same cycle as a clear of the same bit, which separates edge-wins from clear-wins;
- direct lines, whose outputs must follow their level while no pending bit is ever set for them;
- unmapped offsets, which must read as zero and must not disturb any register.

// File: rtl/evt_pkg.sv
package evt_pkg;

    parameter int unsigned NLINES = 32;
    parameter int unsigned ADDR_W = 12;

    typedef logic [NLINES-1:0] line_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RISE_CFG,
        SEL_FALL_CFG,
        SEL_SWTRIG,
        SEL_RISE_PEND,
        SEL_FALL_PEND,
        SEL_MASK,
        SEL_CAP
    } reg_sel_e;

    localparam logic [ADDR_W-1:0] OFS_RISE_CFG  = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] OFS_FALL_CFG  = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] OFS_SWTRIG    = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] OFS_RISE_PEND = ADDR_W'('h0C);
    localparam logic [ADDR_W-1:0] OFS_FALL_PEND = ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] OFS_MASK      = ADDR_W'('h80);
    localparam logic [ADDR_W-1:0] OFS_CAP       = ADDR_W'('h84);

    typedef struct packed {
        logic      wr;
        logic      rd;
        reg_sel_e  sel;
        line_vec_t data;
    } bus_op_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_RISE_CFG:  s = SEL_RISE_CFG;
            OFS_FALL_CFG:  s = SEL_FALL_CFG;
            OFS_SWTRIG:    s = SEL_SWTRIG;
            OFS_RISE_PEND: s = SEL_RISE_PEND;
            OFS_FALL_PEND: s = SEL_FALL_PEND;
            OFS_MASK:      s = SEL_MASK;
            OFS_CAP:       s = SEL_CAP;
            default:       s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Write-strobe vector: data when the op is a write to the given register
    function automatic line_vec_t wr_strobe(input bus_op_t op, input reg_sel_e target);
        return (op.wr && op.sel == target) ? op.data : '0;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/evt_pending.sv
module evt_pending
    import evt_pkg::*;
#(
    parameter line_vec_t CAP = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t lvl,
    input  line_vec_t rise_en,
    input  line_vec_t fall_en,
    input  line_vec_t sw_set,
    input  line_vec_t clr_rise,
    input  line_vec_t clr_fall,
    output line_vec_t rise_pend,
    output line_vec_t fall_pend
);
    line_vec_t prev_q, rp_q, fp_q;
    line_vec_t rise_hit, fall_hit, set_r;

    always_comb begin
        rise_hit = lvl & ~prev_q & rise_en & CAP;
        fall_hit = ~lvl & prev_q & fall_en & CAP;
        set_r    = rise_hit | (sw_set & CAP);
    end

    // Clear is applied before set, so a same-cycle event keeps the bit
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            rp_q   <= '0;
            fp_q   <= '0;
        end else begin
            prev_q <= lvl;
            rp_q   <= (rp_q & ~clr_rise) | set_r;
            fp_q   <= (fp_q & ~clr_fall) | fall_hit;
        end
    end

    assign rise_pend = rp_q;
    assign fall_pend = fp_q;
endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import evt_pkg::*;
#(
    parameter line_vec_t CAP = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  line_vec_t         req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output line_vec_t         rsp_rdata,
    input  line_vec_t         rise_pend,
    input  line_vec_t         fall_pend,
    output line_vec_t         rise_en,
    output line_vec_t         fall_en,
    output line_vec_t         mask,
    output line_vec_t         sw_set,
    output line_vec_t         clr_rise,
    output line_vec_t         clr_fall
);
    bus_op_t   op;
    line_vec_t rsel_q, fsel_q, mask_q;
    line_vec_t rdata_d, rdata_q;
    logic      rvalid_q;

    assign req_ready = 1'b1;

    always_comb begin
        op.wr   = req_valid && req_ready && req_write;
        op.rd   = req_valid && req_ready && !req_write;
        op.sel  = decode_ofs(req_addr);
        op.data = req_wdata;
    end

    assign sw_set   = wr_strobe(op, SEL_SWTRIG);
    assign clr_rise = wr_strobe(op, SEL_RISE_PEND);
    assign clr_fall = wr_strobe(op, SEL_FALL_PEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsel_q <= '0;
            fsel_q <= '0;
            mask_q <= '0;
        end else if (op.wr) begin
            case (op.sel)
                SEL_RISE_CFG: rsel_q <= op.data;
                SEL_FALL_CFG: fsel_q <= op.data;
                SEL_MASK:     mask_q <= op.data;
                default:      ;
            endcase
        end
    end

    always_comb begin
        case (op.sel)
            SEL_RISE_CFG:  rdata_d = rsel_q;
            SEL_FALL_CFG:  rdata_d = fsel_q;
            SEL_RISE_PEND: rdata_d = rise_pend;
            SEL_FALL_PEND: rdata_d = fall_pend;
            SEL_MASK:      rdata_d = mask_q;
            SEL_CAP:       rdata_d = CAP;
            default:       rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= op.rd;
            if (op.rd) rdata_q <= rdata_d;
        end
    end

    assign rsp_valid = rvalid_q;
    assign rsp_rdata = rdata_q;
    assign rise_en   = rsel_q;
    assign fall_en   = fsel_q;
    assign mask      = mask_q;
endmodule

// File: rtl/evt_outs.sv
module evt_outs
    import evt_pkg::*;
#(
    parameter line_vec_t CAP = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t lvl,
    input  line_vec_t rise_pend,
    input  line_vec_t fall_pend,
    input  line_vec_t mask,
    output line_vec_t line_out,
    output logic      irq_out
);
    line_vec_t any_pend, line_d, line_q;
    logic      irq_q;

    always_comb begin
        any_pend = rise_pend | fall_pend;
        line_d   = ((any_pend & CAP) | (lvl & ~CAP)) & mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            line_q <= line_d;
            irq_q  <= |(any_pend & mask);
        end
    end

    assign line_out = line_q;
    assign irq_out  = irq_q;
endmodule

// File: rtl/ext_event_bank.sv
module ext_event_bank
    import evt_pkg::*;
#(
    parameter logic [NLINES-1:0] CAP_LINES   = 32'h00FF_FFFF,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NLINES-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [NLINES-1:0] rsp_rdata,
    input  logic [NLINES-1:0] lines_in,
    output logic [NLINES-1:0] line_out,
    output logic              irq_out
);
    line_vec_t lvl_sync;
    line_vec_t rise_pend_w, fall_pend_w;
    line_vec_t rise_en_w, fall_en_w, mask_w;
    line_vec_t sw_set_w, clr_rise_w, clr_fall_w;

    evt_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lines_in),
        .q   (lvl_sync)
    );

    evt_regs #(.CAP(CAP_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rise_pend (rise_pend_w),
        .fall_pend (fall_pend_w),
        .rise_en   (rise_en_w),
        .fall_en   (fall_en_w),
        .mask      (mask_w),
        .sw_set    (sw_set_w),
        .clr_rise  (clr_rise_w),
        .clr_fall  (clr_fall_w)
    );

    evt_pending #(.CAP(CAP_LINES)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl_sync),
        .rise_en   (rise_en_w),
        .fall_en   (fall_en_w),
        .sw_set    (sw_set_w),
        .clr_rise  (clr_rise_w),
        .clr_fall  (clr_fall_w),
        .rise_pend (rise_pend_w),
        .fall_pend (fall_pend_w)
    );

    evt_outs #(.CAP(CAP_LINES)) u_outs (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl_sync),
        .rise_pend (rise_pend_w),
        .fall_pend (fall_pend_w),
        .mask      (mask_w),
        .line_out  (line_out),
        .irq_out   (irq_out)
    );
endmodule

// File: rtl/ext_event_bank_chk.sv
module ext_event_bank_chk
    import evt_pkg::*;
#(
    parameter logic [NLINES-1:0] CAP = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              irq_out,
    input line_vec_t         line_out,
    input line_vec_t         rise_pend,
    input line_vec_t         fall_pend
);
    logic rd_acc, clr_r_wr, clr_f_wr;

    assign rd_acc   = req_valid && req_ready && !req_write;
    assign clr_r_wr = req_valid && req_ready && req_write && (req_addr == OFS_RISE_PEND);
    assign clr_f_wr = req_valid && req_ready && req_write && (req_addr == OFS_FALL_PEND);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq_out && !rsp_valid && line_out == '0)); // R1
    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst) !clr_r_wr |=> (($past(rise_pend) & ~rise_pend) == '0)); // R5
    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (rst) !clr_f_wr |=> (($past(fall_pend) & ~fall_pend) == '0)); // R5
    AST_IRQ_HAS_LINE: assert property (@(posedge clk) disable iff (rst) irq_out |-> ((line_out & CAP) != '0)); // R7
    AST_DIRECT_NO_PEND: assert property (@(posedge clk) disable iff (rst) ((rise_pend | fall_pend) & ~CAP) == '0); // R8
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst) rd_acc |=> rsp_valid); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !rd_acc |=> !rsp_valid); // R11
    AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst) req_valid |-> req_ready); // R11
endmodule

bind ext_event_bank ext_event_bank_chk #(.CAP(CAP_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .irq_out   (irq_out),
    .line_out  (line_out),
    .rise_pend (rise_pend_w),
    .fall_pend (fall_pend_w)
);

// File: tb/sim_ext_event_bank.sv
module sim_ext_event_bank;
    localparam logic [31:0] CAP = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] lines_in = '0;
    logic        req_ready, rsp_valid, irq_out;
    logic [31:0] rsp_rdata, line_out;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [31:0] m_rsel = '0, m_fsel = '0, m_mask = '0;
    logic [31:0] m_rp = '0, m_fp = '0, m_lines = '0;

    always #10 clk = ~clk;

    ext_event_bank #(.CAP_LINES(CAP)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lines_in(lines_in),
        .line_out(line_out), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_line_out();
        return (((m_rp | m_fp) & CAP) | (m_lines & ~CAP)) & m_mask;
    endfunction

    function automatic logic exp_irq();
        return |((m_rp | m_fp) & m_mask);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R11 no response to write", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 read response valid", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr(a, d);
        case (a)
            12'h000: m_rsel = d;
            12'h004: m_fsel = d;
            12'h008: m_rp   = m_rp | (d & CAP);
            12'h00C: m_rp   = m_rp & ~d;
            12'h010: m_fp   = m_fp & ~d;
            12'h080: m_mask = d;
            default: ;
        endcase
    endtask

    task automatic set_lines(input logic [31:0] v);
        m_rp = m_rp | (v & ~m_lines & CAP & m_rsel);
        m_fp = m_fp | (~v & m_lines & CAP & m_fsel);
        m_lines = v;
        @(negedge clk);
        lines_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_outs(input string tag);
        @(negedge clk);
        chk({"R7 irq_out ", tag}, {31'd0, irq_out}, {31'd0, exp_irq()});
        chk({"R8 line_out ", tag}, line_out, exp_line_out());
    endtask

    task automatic check_regs();
        logic [31:0] d;
        bus_rd(12'h000, d); chk("R2 rising select readback", d, m_rsel);
        bus_rd(12'h004, d); chk("R3 falling select readback", d, m_fsel);
        bus_rd(12'h008, d); chk("R6 trigger reads zero", d, 32'd0);
        bus_rd(12'h00C, d); chk("R2 rising pending", d, m_rp);
        bus_rd(12'h010, d); chk("R3 falling pending", d, m_fp);
        bus_rd(12'h080, d); chk("R7 mask readback", d, m_mask);
        bus_rd(12'h084, d); chk("R8 capability", d, CAP);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq_out after reset", {31'd0, irq_out}, 32'd0);
        chk("R1 line_out after reset", line_out, 32'd0);
        chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R11 req_ready high", {31'd0, req_ready}, 32'd1);
        check_regs();

        // R4: both selects on line 3, neither on line 5
        do_wr(12'h000, 32'h0000_0008);
        do_wr(12'h004, 32'h0000_0008);
        do_wr(12'h080, 32'hFFFF_FFFF);
        set_lines(32'h0000_0028);
        bus_rd(12'h00C, d); chk("R4 both: rise latched", d, 32'h0000_0008);
        bus_rd(12'h010, d); chk("R4 both: fall untouched", d, 32'h0);
        set_lines(32'h0000_0000);
        bus_rd(12'h010, d); chk("R4 both: fall latched", d, 32'h0000_0008);
        bus_rd(12'h00C, d); chk("R4 neither: line 5 not latched", d, 32'h0000_0008);
        check_outs("dual edge");

        // R5: zero write no effect, then independent one-hot clears
        do_wr(12'h00C, 32'h0);
        bus_rd(12'h00C, d); chk("R5 zero write keeps rising pending", d, 32'h0000_0008);
        do_wr(12'h00C, 32'h0000_0008);
        bus_rd(12'h00C, d); chk("R5 rising cleared", d, 32'h0);
        bus_rd(12'h010, d); chk("R5 falling kept", d, 32'h0000_0008);
        do_wr(12'h010, 32'h0000_0008);
        check_outs("after clears");

        // R6: software trigger on configurable and direct lines
        do_wr(12'h008, 32'h0000_0004);
        bus_rd(12'h00C, d); chk("R6 trigger sets rising pending", d, 32'h0000_0004);
        do_wr(12'h008, 32'h1000_0000);
        bus_rd(12'h00C, d); chk("R8 trigger on direct line ignored", d, 32'h0000_0004);
        check_outs("after trigger");
        do_wr(12'h00C, 32'h0000_0004);

        // R8: direct line level passes through the mask
        set_lines(32'h1000_0000);
        check_outs("direct high");
        chk("R8 direct line 28 follows level", line_out & 32'h1000_0000, 32'h1000_0000);
        do_wr(12'h084, 32'h0);
        bus_rd(12'h084, d); chk("R8 capability read-only", d, CAP);
        set_lines(32'h0);

        // R9: edge and clear in the same cycle on line 0
        do_wr(12'h000, 32'h0000_0001);
        do_wr(12'h008, 32'h0000_0001);
        @(negedge clk); lines_in = 32'h0000_0001;
        @(negedge clk);
        bus_wr(12'h00C, 32'h0000_0001);
        m_lines = 32'h0000_0001;
        repeat (3) @(negedge clk);
        bus_rd(12'h00C, d); chk("R9 edge wins over clear", d, 32'h0000_0001);
        do_wr(12'h00C, 32'h0000_0001);
        bus_rd(12'h00C, d); chk("R5 later clear works", d, 32'h0);

        // R10: undefined offsets
        do_wr(12'h044, 32'hFFFF_FFFF);
        do_wr(12'h081, 32'hFFFF_FFFF);
        bus_rd(12'h044, d); chk("R10 undefined reads zero", d, 32'h0);
        bus_rd(12'h0FC, d); chk("R10 undefined high offset reads zero", d, 32'h0);
        check_regs();
        check_outs("after undefined writes");

        // Random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            logic [31:0] oh;
            op = int'($urandom % 6);
            oh = 32'h1 << ($urandom % 32);
            case (op)
                0: do_wr(12'h000, $urandom);
                1: do_wr(12'h004, $urandom);
                2: do_wr(12'h080, $urandom);
                3: set_lines(m_lines ^ ($urandom & $urandom));
                4: do_wr(($urandom % 2) ? 12'h00C : 12'h010, oh);
                default: do_wr(12'h008, oh);
            endcase
            check_outs("random");
            if (it % 10 == 9) check_regs();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule